// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block turns a transfer request from a flash sequencer into the serial clock and active-low device-select waveforms seen at the flash pins. It takes a 32-bit configuration word and a packed gap word. From them it gets an enable, clock polarity and phase, a clock divisor, a 4-bit select field with a decoder-mode flag, and four gaps counted in reference-clock cycles. These gaps are a lead-in, a tail, a minimum deselect time and an extra pause when the target device changes.

A start pulse, given while the block is idle, latches the settings and the requested bit count. The block then pulls the select low and waits out the lead-in. It produces two SCLK edges per bit, waits out the tail and releases the select. It then enforces the deselect time before it reports idle again. Each SCLK edge comes with a launch or a sample strobe for the external shifter, chosen by the phase setting. A done pulse marks the release of the select.

Top module: `spi_sclk_cs_timer`

## Requirements
- R1: Out of reset all select lines are high, idle is high, done and both strobes are low and SCLK is low. While idle, SCLK follows the polarity bit (config bit 1) one cycle later.
- R2: With divisor N in config bits 22:19, successive SCLK edges are N+1 reference cycles apart. A transfer of B bits gives exactly 2*B edges and leaves SCLK back at the polarity level.
- R3: The first SCLK edge comes L+1 cycles after the select falls, where L is gap-word bits 7:0.
- R4: The select rises T+1 cycles after the last SCLK edge, where T is gap-word bits 15:8. With B=0 no edge is made, and the select rises T+1 cycles after the point where the first edge would have been.
- R5: Idle returns M+1 cycles after the select rises, where M is gap-word bits 31:24. A start is accepted only while idle.
- R6: When the select field differs from that of the previous transfer, the select falls S cycles after the start, where S is gap-word bits 23:16. Otherwise, and for the first transfer after reset, it falls in the first cycle after the start. S=0 adds nothing.
- R7: The select field is config bits 13:10 and decoder mode is config bit 9. In decoder mode the field is driven unchanged on the four lines during a transfer. In direct mode only the line of the lowest-numbered zero bit of the field goes low (1110 selects line 0, 0101 selects line 1).
- R8: With phase 0 (config bit 2 clear) there is a launch strobe when the select falls, a sample strobe on odd edges and a launch strobe on even edges except the last. With phase 1 odd edges launch and even edges sample. Either way a B-bit transfer gives B launches and B samples.
- R9: Done pulses for exactly one cycle, in the first cycle the select is high again.
- R10: With config bit 0 low, starts are ignored. Dropping it during a transfer returns the block to idle on the next cycle, with all select lines high, SCLK at polarity level and no done pulse.
- R11: Divisor, select field, mode, gaps and bit count are latched at the start. A start or a configuration change during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Enable, polarity, phase, decoder mode, select field, divisor |
| dly_word | input | 32 | Four packed gap counts: lead, tail, device switch, deselect |
| xfer_start | input | 1 | One-cycle transfer request |
| xfer_bits | input | 8 | Number of bits in the transfer |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low device select lines |
| edge_launch | output | 1 | Shifter should drive the next bit this cycle |
| edge_sample | output | 1 | Shifter should capture input data this cycle |
| xfer_done | output | 1 | Pulse when the select is released |
| idle | output | 1 | No transfer and no pending gap |

## Verification
The bench builds the block with its default widths: a 4-bit divisor, 8-bit gaps and an 8-bit bit count. With these, divisor values from 0 to 15, gaps from 0 to 10 and transfers of 0 to 5 bits can each be timed cycle by cycle within a short run. The vectors cover all four clock modes and both select modes. They include a repeated device, a device switch with a zero switch gap, a field with two zero bits, and a zero-bit transfer. Directed steps cover a start while disabled, a start and a configuration change during a transfer, and an abort by dropping the enable.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

    // Configuration word bit positions (software decodes these)
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_CPOL_BIT = 1;
    localparam int CFG_CPHA_BIT = 2;
    localparam int CFG_DEC_BIT  = 9;
    localparam int CFG_SEL_LSB  = 10;
    localparam int CFG_DIV_LSB  = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWAP,
        ST_LEAD,
        ST_RUN,
        ST_TAIL,
        ST_REST
    } tim_state_e;

endpackage

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] hc_d, hc_q;

    always_comb begin
        hc_d = hc_q;
        if (!run) begin
            hc_d = div;
        end else if (hc_q == '0) begin
            hc_d = div;
        end else begin
            hc_d = hc_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hc_q <= '0;
        else        hc_q <= hc_d;
    end

    assign tick = run && (hc_q == '0);

    // Half periods longer than one cycle never produce back-to-back ticks
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && run) |=> !tick);

endmodule

// File: rtl/cs_select_drive.sv
module cs_select_drive #(
    parameter int SEL_W = 4
) (
    input  logic             active,
    input  logic             dec_mode,
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] cs_n
);
    logic [SEL_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (!sel[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
        if (!active)       cs_n = '1;
        else if (dec_mode) cs_n = sel;
        else               cs_n = ~pick;
    end

endmodule

// File: rtl/spi_sclk_cs_timer.sv
module spi_sclk_cs_timer
    import spi_tim_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int DIV_W  = 4,
    parameter int GAP_W  = 8,
    parameter int BITS_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          cfg_word,
    input  logic [4*GAP_W-1:0]   dly_word,
    input  logic                 xfer_start,
    input  logic [BITS_W-1:0]    xfer_bits,
    output logic                 sclk,
    output logic [SEL_W-1:0]     cs_n,
    output logic                 edge_launch,
    output logic                 edge_sample,
    output logic                 xfer_done,
    output logic                 idle
);
    localparam int EDGE_W   = BITS_W + 1;
    localparam int DLY_W    = 4 * GAP_W;
    localparam int LEAD_LSB = 0;
    localparam int TAIL_LSB = GAP_W;
    localparam int SWAP_LSB = 2 * GAP_W;
    localparam int REST_LSB = 3 * GAP_W;

    typedef struct packed {
        tim_state_e        state;
        logic [GAP_W-1:0]  cnt;
        logic [EDGE_W-1:0] edges;
        logic [BITS_W-1:0] bits;
        logic [DIV_W-1:0]  div;
        logic [SEL_W-1:0]  sel;
        logic              dec;
        logic              cpha;
        logic [DLY_W-1:0]  gaps;
        logic [SEL_W-1:0]  last_sel;
        logic              last_ok;
        logic              sclk;
        logic              cs_act;
        logic              launch;
        logic              sample;
        logic              done;
    } regs_t;

    regs_t d, q;

    logic              en, cfg_cpol, cfg_cpha, cfg_dec;
    logic [SEL_W-1:0]  cfg_sel;
    logic [DIV_W-1:0]  cfg_div;
    logic [GAP_W-1:0]  new_lead, new_swap, q_lead, q_tail, q_rest;
    logic [EDGE_W-1:0] total_edges, edge_nx;
    logic              tick;
    logic              unused_cfg_bits;

    assign en        = cfg_word[CFG_EN_BIT];
    assign cfg_cpol  = cfg_word[CFG_CPOL_BIT];
    assign cfg_cpha  = cfg_word[CFG_CPHA_BIT];
    assign cfg_dec   = cfg_word[CFG_DEC_BIT];
    assign cfg_sel   = cfg_word[CFG_SEL_LSB +: SEL_W];
    assign cfg_div   = cfg_word[CFG_DIV_LSB +: DIV_W];
    assign unused_cfg_bits = ^{cfg_word[31:23], cfg_word[18:14], cfg_word[8:3]};

    assign new_lead  = dly_word[LEAD_LSB +: GAP_W];
    assign new_swap  = dly_word[SWAP_LSB +: GAP_W];
    assign q_lead    = q.gaps[LEAD_LSB +: GAP_W];
    assign q_tail    = q.gaps[TAIL_LSB +: GAP_W];
    assign q_rest    = q.gaps[REST_LSB +: GAP_W];
    assign total_edges = {q.bits, 1'b0};
    assign edge_nx     = q.edges + 1'b1;

    sclk_half_timer #(.DIV_W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state == ST_RUN),
        .div   (q.div),
        .tick  (tick)
    );

    always_comb begin
        d        = q;
        d.launch = 1'b0;
        d.sample = 1'b0;
        d.done   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                d.sclk   = cfg_cpol;
                d.cs_act = 1'b0;
                if (en && xfer_start) begin
                    d.sel      = cfg_sel;
                    d.dec      = cfg_dec;
                    d.div      = cfg_div;
                    d.cpha     = cfg_cpha;
                    d.gaps     = dly_word;
                    d.bits     = xfer_bits;
                    d.edges    = '0;
                    d.last_sel = cfg_sel;
                    d.last_ok  = 1'b1;
                    if (q.last_ok && cfg_sel != q.last_sel && new_swap != '0) begin
                        d.state = ST_SWAP;
                        d.cnt   = new_swap - 1'b1;
                    end else begin
                        d.state  = ST_LEAD;
                        d.cnt    = new_lead;
                        d.cs_act = 1'b1;
                        d.launch = !cfg_cpha && (xfer_bits != '0);
                    end
                end
            end
            ST_SWAP: begin
                if (q.cnt == '0) begin
                    d.state  = ST_LEAD;
                    d.cnt    = q_lead;
                    d.cs_act = 1'b1;
                    d.launch = !q.cpha && (q.bits != '0);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_LEAD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.bits == '0) begin
                    d.state = ST_TAIL;
                    d.cnt   = q_tail;
                end else begin
                    d.state  = ST_RUN;
                    d.sclk   = ~q.sclk;
                    d.edges  = EDGE_W'(1);
                    d.sample = !q.cpha;
                    d.launch = q.cpha;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    d.sclk   = ~q.sclk;
                    d.edges  = edge_nx;
                    d.sample = edge_nx[0] ^ q.cpha;
                    d.launch = q.cpha ? edge_nx[0]
                                      : (!edge_nx[0] && edge_nx != total_edges);
                    if (edge_nx == total_edges) begin
                        d.state = ST_TAIL;
                        d.cnt   = q_tail;
                    end
                end
            end
            ST_TAIL: begin
                if (q.cnt == '0) begin
                    d.state  = ST_REST;
                    d.cnt    = q_rest;
                    d.cs_act = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REST: begin
                if (q.cnt == '0) d.state = ST_IDLE;
                else             d.cnt   = q.cnt - 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
        if (!en) begin
            d.state  = ST_IDLE;
            d.cs_act = 1'b0;
            d.sclk   = cfg_cpol;
            d.launch = 1'b0;
            d.sample = 1'b0;
            d.done   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    cs_select_drive #(.SEL_W(SEL_W)) u_cs (
        .active   (q.cs_act),
        .dec_mode (q.dec),
        .sel      (q.sel),
        .cs_n     (cs_n)
    );

    assign sclk        = q.sclk;
    assign edge_launch = q.launch;
    assign edge_sample = q.sample;
    assign xfer_done   = q.done;
    assign idle        = (q.state == ST_IDLE);

    // Direct mode never selects two devices at once
    p_one_device_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.dec |-> $countones(~cs_n) <= 1);

    // Done only appears with the select released and the deselect gap pending
    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (cs_n == '1 && !idle));

    // One strobe kind per edge
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_launch && edge_sample));

    // No shifter activity while idle
    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!edge_launch && !edge_sample && !xfer_done));

    // Disabling forces the lines high and the block idle on the next cycle
    p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[CFG_EN_BIT] |=> (cs_n == '1 && idle));

endmodule

// File: tb/tb_spi_sclk_cs_timer.sv
module tb_spi_sclk_cs_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [31:0] dly_word = '0;
    logic        xfer_start = 1'b0;
    logic [7:0]  xfer_bits = '0;
    logic        sclk, edge_launch, edge_sample, xfer_done, idle;
    logic [3:0]  cs_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] last_sel = '0;
    bit         last_ok = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sclk_cs_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .dly_word(dly_word),
        .xfer_start(xfer_start), .xfer_bits(xfer_bits), .sclk(sclk), .cs_n(cs_n),
        .edge_launch(edge_launch), .edge_sample(edge_sample),
        .xfer_done(xfer_done), .idle(idle)
    );

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [3:0] div;
        logic [3:0] sel;
        logic       dec;
        logic [7:0] lead;
        logic [7:0] tail;
        logic [7:0] swap;
        logic [7:0] rest;
        logic [7:0] bits;
        logic       poke;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd0,  4'hE, 1'b0, 8'd2,  8'd1,  8'd3, 8'd2,  8'd4, 1'b0},
        '{1'b1, 1'b1, 4'd1,  4'hE, 1'b0, 8'd0,  8'd0,  8'd3, 8'd0,  8'd3, 1'b0},
        '{1'b0, 1'b1, 4'd2,  4'hD, 1'b0, 8'd1,  8'd2,  8'd3, 8'd1,  8'd2, 1'b1},
        '{1'b1, 1'b0, 4'd0,  4'hB, 1'b0, 8'd0,  8'd0,  8'd0, 8'd0,  8'd1, 1'b0},
        '{1'b0, 1'b0, 4'd3,  4'h5, 1'b1, 8'd3,  8'd3,  8'd2, 8'd4,  8'd2, 1'b0},
        '{1'b1, 1'b1, 4'd15, 4'h5, 1'b0, 8'd1,  8'd0,  8'd2, 8'd3,  8'd1, 1'b1},
        '{1'b0, 1'b0, 4'd2,  4'h5, 1'b0, 8'd2,  8'd3,  8'd5, 8'd1,  8'd0, 1'b0},
        '{1'b0, 1'b1, 4'd15, 4'h7, 1'b0, 8'd10, 8'd10, 8'd0, 8'd10, 8'd5, 1'b0}
    };

    function automatic logic [31:0] make_cfg(input logic en, input logic cpol,
        input logic cpha, input logic [3:0] div, input logic [3:0] sel, input logic dec);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = cpol; w[2] = cpha; w[9] = dec;
        w[13:10] = sel; w[22:19] = div;
        return w;
    endfunction

    function automatic logic [3:0] expect_cs(input logic [3:0] sel, input logic dec);
        if (dec) return sel;
        for (int i = 0; i < 4; i++) begin
            if (!sel[i]) return ~(4'b0001 << i);
        end
        return 4'hF;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int s_eff, h, b, e_first, e_end, e_rise, e_idle;
        int t_fall, t_first, t_last, t_rise, t_done, t_idle, n_edges, n_lau, n_smp, n_done;
        logic [3:0] cs_seen;
        logic prev;
        logic [31:0] cfg;
        bit sw;
        sw = last_ok && (v.sel != last_sel) && (v.swap != 0);
        s_eff = sw ? int'(v.swap) : 0;
        h = int'(v.div) + 1;
        b = int'(v.bits);
        e_first = s_eff + int'(v.lead) + 1;
        e_end = (b > 0) ? e_first + (2*b - 1) * h : e_first;
        e_rise = e_end + int'(v.tail) + 1;
        e_idle = e_rise + int'(v.rest) + 1;
        t_fall = -1; t_first = -1; t_last = -1; t_rise = -1; t_done = -1; t_idle = -1;
        n_edges = 0; n_lau = 0; n_smp = 0; n_done = 0; cs_seen = 4'hF;
        cfg = make_cfg(1'b1, v.cpol, v.cpha, v.div, v.sel, v.dec);
        @(negedge clk);
        cfg_word = cfg;
        dly_word = {v.rest, v.swap, v.tail, v.lead};
        xfer_bits = v.bits;
        xfer_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        prev = v.cpol;
        for (int t = 0; t < 4000; t++) begin
            if (cs_n != 4'hF && t_fall < 0) begin t_fall = t; cs_seen = cs_n; end
            if (t_fall >= 0 && t_rise < 0 && cs_n == 4'hF) t_rise = t;
            if (sclk != prev) begin
                n_edges++;
                if (t_first < 0) t_first = t;
                t_last = t;
            end
            prev = sclk;
            if (edge_launch) n_lau++;
            if (edge_sample) n_smp++;
            if (xfer_done) begin n_done++; t_done = t; end
            if (idle) begin t_idle = t; break; end
            if (v.poke && t == 2) begin
                xfer_start = 1'b1;
                cfg_word = make_cfg(1'b1, v.cpol, v.cpha, ~v.div, ~v.sel, v.dec);
                xfer_bits = 8'd7;
            end
            if (v.poke && t == 3) begin
                xfer_start = 1'b0;
                cfg_word = cfg;
            end
            @(negedge clk);
        end
        $display("vector %0d", idx);
        chk("R6 select fall time", t_fall, s_eff);
        chk("R7 select line value", int'(cs_seen), int'(expect_cs(v.sel, v.dec)));
        chk("R2 edge count", n_edges, 2*b);
        if (b > 0) begin
            chk("R3 first edge time", t_first, e_first);
            chk("R2 last edge time", t_last, e_end);
        end
        chk("R2 final sclk level", int'(sclk), int'(v.cpol));
        chk("R8 launch count", n_lau, b);
        chk("R8 sample count", n_smp, b);
        chk("R4 select rise time", t_rise, e_rise);
        chk("R9 done time", t_done, e_rise);
        chk("R9 done pulses", n_done, 1);
        chk("R5 idle return time", t_idle, e_idle);
        if (v.poke) chk("R11 busy start and config ignored", t_idle, e_idle);
        last_sel = v.sel;
        last_ok = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset select lines", int'(cs_n), 15);
        chk("R1 reset idle", int'(idle), 1);
        chk("R1 reset done", int'(xfer_done), 0);
        chk("R1 reset sclk", int'(sclk), 0);
        chk("R1 reset strobes", int'(edge_launch | edge_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_word = make_cfg(1'b0, 1'b1, 1'b0, 4'd0, 4'hE, 1'b0);
        repeat (2) @(negedge clk);
        chk("R1 idle sclk follows polarity", int'(sclk), 1);

        // R10: start while disabled is ignored
        dly_word = 32'h0101_0101;
        xfer_bits = 8'd4;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        repeat (4) begin
            chk("R10 disabled start ignored cs", int'(cs_n), 15);
            chk("R10 disabled start ignored idle", int'(idle), 1);
            @(negedge clk);
        end

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: abort by dropping enable mid-transfer
        @(negedge clk);
        cfg_word = make_cfg(1'b1, 1'b1, 1'b0, 4'd15, 4'hE, 1'b0);
        dly_word = 32'h0000_0000;
        xfer_bits = 8'd8;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 transfer active before abort", int'(cs_n), 14);
        cfg_word[0] = 1'b0;
        @(negedge clk);
        chk("R10 abort releases select", int'(cs_n), 15);
        chk("R10 abort idle", int'(idle), 1);
        chk("R10 abort sclk at polarity", int'(sclk), 1);
        repeat (10) begin
            chk("R10 abort no done", int'(xfer_done), 0);
            @(negedge clk);
        end
        summary();
        $finish;
    end

endmodule